// File: doc/BRIEF.md
# Multi-Rail Voltage Command Scheduler

This block keeps a voltage target, a slew rate and an operating-mode bit for each of several supply rails, all steered by one decoded command stream. A command names a rail selector, an operation and a 16-bit data word. Voltage writes can take effect at once, or they can be parked as pending. Any later command that executes commits every parked voltage in the same clock cycle, so rails that must move together all start in step.

For every rail the block drives a reference code in millivolts. On each pulse of a one-microsecond tick, the code moves toward that rail's target by no more than the programmed rate. It stops exactly on the target. A per-rail busy flag is high whenever the reference and the target differ. A reset-to-default operation puts a rail's target back to the value given by a parameter. Every accepted command returns a two-bit acknowledge code one cycle later.

Top module: `vrail_sched`

## Requirements
- R1: During and right after synchronous reset, every rail's reference and target equal DEF_VOLT and its rate equals DEF_RATE. The mode bits, busy flags, pending flags and ack_valid are all 0.
- R2: A command is acknowledged in the next cycle: ack_valid is high for one cycle with ack_code 2'b00 when the selector is below NUM_RAILS. It carries 2'b11 when the selector is NUM_RAILS or more, and in that case nothing changes and nothing is committed. ack_valid is 0 in any cycle that follows a cycle without a command.
- R3: Opcode 0 (set voltage) with cmd_hold low loads the rail's target from cmd_data in the next cycle. 1 LSB is 1 mV, so 16'h0000 is 0 V and 16'hFFFF is 65.535 V.
- R4: Opcode 0 with cmd_hold high stages cmd_data as that rail's pending voltage and changes no target. Staging a rail that already has a pending value replaces that value. Any accepted command that is not a held voltage write moves every pending value into its target in one cycle. For the rail it addresses directly, that command's own effect takes priority.
- R5: On each us_tick the reference moves toward the target by at most the rate (1 mV/µs per LSB). It never passes the target, and it lands on the target exactly.
- R6: When the rate is 0, the reference steps straight to the target on the next us_tick.
- R7: Opcode 1 loads the rail's rate from cmd_data.
- R8: Opcode 2 sets the rail's target to DEF_VOLT and discards that rail's pending value.
- R9: Opcode 3 copies cmd_data[0] into the rail's mode output bit. 1 selects maximum efficiency and 0 selects maximum power.
- R10: busy[i] is high exactly while rail i's reference differs from its target.
- R11: A reference changes only in a cycle that follows a us_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 0 voltage, 1 rate, 2 default, 3 mode |
| cmd_rail | input | 4 | Rail selector |
| cmd_hold | input | 1 | Stage a voltage write as pending |
| cmd_data | input | 16 | Command data word |
| us_tick | input | 1 | One-microsecond pulse |
| ack_valid | output | 1 | Acknowledge present |
| ack_code | output | 2 | 00 done, 11 bad selector |
| vref | output | NUM_RAILS*16 | Reference codes, rail i in bits [16*i +: 16] |
| busy | output | NUM_RAILS | Reference still moving |
| mode_eff | output | NUM_RAILS | Efficiency mode selected |

## Verification
A commit and a ramp tick can land in the same cycle. The bench provokes this by sending the committing command together with a us_tick after several rails have been staged. The tick must still step each rail toward its old target, and the committed targets must apply only from the following tick. An arithmetic model of targets, pending values and rates judges every reference and busy flag after each cycle. The same overlap is also exercised when a voltage write and a tick share a cycle on a rail that is in the middle of a ramp.

// File: rtl/vsched_pkg.sv
package vsched_pkg;

    localparam int CODE_W = 16;
    localparam int SEL_W  = 4;

    typedef enum logic [1:0] {
        OP_VOLT  = 2'd0,
        OP_RATE  = 2'd1,
        OP_DFLT  = 2'd2,
        OP_MODE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ACK_OK      = 2'b00,
        ACK_BAD_SEL = 2'b11
    } ack_e;

    typedef struct packed {
        logic              set_volt;
        logic              stage_volt;
        logic              set_rate;
        logic              set_dflt;
        logic              set_mode;
        logic [CODE_W-1:0] data;
    } rail_wr_t;

    function automatic logic [CODE_W-1:0] ramp_step(
        input logic [CODE_W-1:0] cur,
        input logic [CODE_W-1:0] tgt,
        input logic [CODE_W-1:0] rate
    );
        logic [CODE_W-1:0] gap;
        if (tgt > cur) begin
            gap = tgt - cur;
            if (rate == '0 || gap <= rate) return tgt;
            return cur + rate;
        end else if (tgt < cur) begin
            gap = cur - tgt;
            if (rate == '0 || gap <= rate) return tgt;
            return cur - rate;
        end
        return cur;
    endfunction

endpackage

// File: rtl/vsched_decode.sv
module vsched_decode
    import vsched_pkg::*;
#(
    parameter int NUM_RAILS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_valid,
    input  logic [1:0]                 cmd_op,
    input  logic [SEL_W-1:0]           cmd_rail,
    input  logic                       cmd_hold,
    input  logic [CODE_W-1:0]          cmd_data,
    output rail_wr_t [NUM_RAILS-1:0]   wr,
    output logic                       commit,
    output logic                       ack_valid,
    output logic [1:0]                 ack_code
);

    logic sel_ok;
    logic held_volt;
    op_e  op;

    assign op        = op_e'(cmd_op);
    assign sel_ok    = (32'(cmd_rail) < NUM_RAILS);
    assign held_volt = (op == OP_VOLT) && cmd_hold;
    assign commit    = cmd_valid && sel_ok && !held_volt;

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_sel
        logic hit;
        assign hit = cmd_valid && (32'(cmd_rail) == i);
        always_comb begin
            wr[i]            = '0;
            wr[i].data       = cmd_data;
            wr[i].set_volt   = hit && (op == OP_VOLT) && !cmd_hold;
            wr[i].stage_volt = hit && held_volt;
            wr[i].set_rate   = hit && (op == OP_RATE);
            wr[i].set_dflt   = hit && (op == OP_DFLT);
            wr[i].set_mode   = hit && (op == OP_MODE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_valid <= 1'b0;
            ack_code  <= ACK_OK;
        end else begin
            ack_valid <= cmd_valid;
            ack_code  <= sel_ok ? ACK_OK : ACK_BAD_SEL;
        end
    end

    // R2: bad selector acknowledged with 11
    a_r2_bad_sel: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && (32'(cmd_rail) >= NUM_RAILS) |=> ack_valid && ack_code == ACK_BAD_SEL);

    // R2: good selector acknowledged with 00
    a_r2_good_sel: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && (32'(cmd_rail) < NUM_RAILS) |=> ack_valid && ack_code == ACK_OK);

    // R2: no acknowledge without a command
    a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !ack_valid);

endmodule

// File: rtl/vsched_rail.sv
module vsched_rail
    import vsched_pkg::*;
#(
    parameter logic [CODE_W-1:0] DEF_VOLT = 16'd800,
    parameter logic [CODE_W-1:0] DEF_RATE = 16'd10
) (
    input  logic              clk,
    input  logic              rst,
    input  rail_wr_t          wr,
    input  logic              commit,
    input  logic              us_tick,
    output logic [CODE_W-1:0] vref,
    output logic              busy,
    output logic              mode_eff
);

    logic [CODE_W-1:0] tgt;
    logic [CODE_W-1:0] rate;
    logic [CODE_W-1:0] pval;
    logic              pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt  <= DEF_VOLT;
            pval <= DEF_VOLT;
            pend <= 1'b0;
        end else if (wr.set_volt) begin
            tgt  <= wr.data;
            pend <= 1'b0;
        end else if (wr.set_dflt) begin
            tgt  <= DEF_VOLT;
            pend <= 1'b0;
        end else if (wr.stage_volt) begin
            pval <= wr.data;
            pend <= 1'b1;
        end else if (commit && pend) begin
            tgt  <= pval;
            pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate     <= DEF_RATE;
            mode_eff <= 1'b0;
        end else begin
            if (wr.set_rate) rate     <= wr.data;
            if (wr.set_mode) mode_eff <= wr.data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          vref <= DEF_VOLT;
        else if (us_tick) vref <= ramp_step(vref, tgt, rate);
    end

    assign busy = (vref != tgt);

    // R11: reference frozen between ticks
    a_r11_still_without_tick: assert property (@(posedge clk) disable iff (rst)
        !us_tick |=> $stable(vref));

    // R5: step bounded by the rate
    a_r5_step_bound: assert property (@(posedge clk) disable iff (rst)
        us_tick && rate != '0 |=>
        ((vref >= $past(vref)) ? (vref - $past(vref)) : ($past(vref) - vref)) <= $past(rate));

    // R5: upward ramp never passes the target
    a_r5_no_overshoot_up: assert property (@(posedge clk) disable iff (rst)
        us_tick && tgt >= vref |=> vref >= $past(vref) && vref <= $past(tgt));

    // R5: downward ramp never passes the target
    a_r5_no_overshoot_dn: assert property (@(posedge clk) disable iff (rst)
        us_tick && tgt <= vref |=> vref <= $past(vref) && vref >= $past(tgt));

    // R6: zero rate jumps straight to the target
    a_r6_zero_rate_jump: assert property (@(posedge clk) disable iff (rst)
        us_tick && rate == '0 |=> vref == $past(tgt));

    // R4: a commit moves the pending value into the target
    a_r4_commit_applies: assert property (@(posedge clk) disable iff (rst)
        commit && pend && !wr.set_volt && !wr.set_dflt |=> tgt == $past(pval) && !pend);

    // R8: default command discards pending
    a_r8_dflt_clears: assert property (@(posedge clk) disable iff (rst)
        wr.set_dflt |=> tgt == DEF_VOLT && !pend);

endmodule

// File: rtl/vrail_sched.sv
module vrail_sched
    import vsched_pkg::*;
#(
    parameter int                NUM_RAILS = 4,
    parameter logic [CODE_W-1:0] DEF_VOLT  = 16'd800,
    parameter logic [CODE_W-1:0] DEF_RATE  = 16'd10
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_valid,
    input  logic [1:0]                    cmd_op,
    input  logic [SEL_W-1:0]              cmd_rail,
    input  logic                          cmd_hold,
    input  logic [CODE_W-1:0]             cmd_data,
    input  logic                          us_tick,
    output logic                          ack_valid,
    output logic [1:0]                    ack_code,
    output logic [NUM_RAILS*CODE_W-1:0]   vref,
    output logic [NUM_RAILS-1:0]          busy,
    output logic [NUM_RAILS-1:0]          mode_eff
);

    rail_wr_t [NUM_RAILS-1:0] wr;
    logic                     commit;

    vsched_decode #(.NUM_RAILS(NUM_RAILS)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_rail  (cmd_rail),
        .cmd_hold  (cmd_hold),
        .cmd_data  (cmd_data),
        .wr        (wr),
        .commit    (commit),
        .ack_valid (ack_valid),
        .ack_code  (ack_code)
    );

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
        vsched_rail #(.DEF_VOLT(DEF_VOLT), .DEF_RATE(DEF_RATE)) u_rail (
            .clk      (clk),
            .rst      (rst),
            .wr       (wr[i]),
            .commit   (commit),
            .us_tick  (us_tick),
            .vref     (vref[i*CODE_W +: CODE_W]),
            .busy     (busy[i]),
            .mode_eff (mode_eff[i])
        );
    end

    // R1: all rails settled right after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> busy == '0 && mode_eff == '0 && !ack_valid);

endmodule

// File: tb/vrail_sched_test.sv
module vrail_sched_test;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int DV = 800;
    localparam int DR = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [3:0] cmd_rail = '0;
    logic cmd_hold = 1'b0;
    logic [15:0] cmd_data = '0;
    logic us_tick = 1'b0;
    logic ack_valid;
    logic [1:0] ack_code;
    logic [N*16-1:0] vref;
    logic [N-1:0] busy;
    logic [N-1:0] mode_eff;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    int m_tgt[N], m_ref[N], m_rate[N], m_mode[N], m_pend[N], m_pval[N];

    always #(CLK_PERIOD/2) clk = ~clk;

    vrail_sched #(.NUM_RAILS(N), .DEF_VOLT(16'(DV)), .DEF_RATE(16'(DR))) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_rail(cmd_rail), .cmd_hold(cmd_hold), .cmd_data(cmd_data),
        .us_tick(us_tick), .ack_valid(ack_valid), .ack_code(ack_code),
        .vref(vref), .busy(busy), .mode_eff(mode_eff)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_ramp(input int cur, input int tgt, input int rate);
        int gap = (tgt > cur) ? tgt - cur : cur - tgt;
        if (rate == 0 || gap <= rate) return tgt;
        return (tgt > cur) ? cur + rate : cur - rate;
    endfunction

    function automatic bit any_busy();
        for (int r = 0; r < N; r++) if (m_ref[r] != m_tgt[r]) return 1;
        return 0;
    endfunction

    task automatic compare_all(input string tag, input bit v, input int eack);
        chk({tag, " R2 ack_valid"}, int'(ack_valid), int'(v));
        if (v) chk({tag, " R2 ack_code"}, int'(ack_code), eack);
        for (int r = 0; r < N; r++) begin
            chk($sformatf("%s R5 vref[%0d]", tag, r), int'(vref[r*16 +: 16]), m_ref[r]);
            chk($sformatf("%s R10 busy[%0d]", tag, r), int'(busy[r]), int'(m_ref[r] != m_tgt[r]));
            chk($sformatf("%s R9 mode[%0d]", tag, r), int'(mode_eff[r]), m_mode[r]);
        end
    endtask

    // one clock: optional command and optional tick, then model update and compare
    task automatic cyc(input string tag, input bit v, input int op, input int rail,
                       input bit hold, input int data, input bit tk);
        int eack = 0;
        cmd_valid = v; cmd_op = 2'(op); cmd_rail = 4'(rail);
        cmd_hold = hold; cmd_data = 16'(data); us_tick = tk;
        @(posedge clk);
        if (tk) for (int r = 0; r < N; r++) m_ref[r] = model_ramp(m_ref[r], m_tgt[r], m_rate[r]);
        if (v) begin
            if (rail >= N) eack = 3;
            else begin
                bool_apply(op, rail, hold, data);
            end
        end
        @(negedge clk);
        cmd_valid = 0; us_tick = 0;
        compare_all(tag, v, eack);
    endtask

    task automatic bool_apply(input int op, input int rail, input bit hold, input int data);
        bit commits = !(op == 0 && hold);
        case (op)
            0: if (hold) begin m_pend[rail] = 1; m_pval[rail] = data; end
               else begin m_tgt[rail] = data; m_pend[rail] = 0; end
            1: m_rate[rail] = data;
            2: begin m_tgt[rail] = DV; m_pend[rail] = 0; end
            default: m_mode[rail] = data & 1;
        endcase
        if (commits)
            for (int r = 0; r < N; r++)
                if (m_pend[r]) begin m_tgt[r] = m_pval[r]; m_pend[r] = 0; end
    endtask

    task automatic settle(input string tag);
        int guard = 0;
        while (any_busy() && guard < 400) begin
            cyc(tag, 0, 0, 0, 0, 0, 1);
            guard++;
        end
        chk({tag, " R5 settled"}, int'(any_busy()), 0);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        for (int r = 0; r < N; r++) begin
            m_tgt[r] = DV; m_ref[r] = DV; m_rate[r] = DR;
            m_mode[r] = 0; m_pend[r] = 0; m_pval[r] = 0;
        end
        repeat (3) @(negedge clk);
        compare_all("R1 in reset", 0, 0);
        rst = 0;
        @(negedge clk);
        compare_all("R1 after reset", 0, 0);
        cyc("R1 idle tick", 0, 0, 0, 0, 0, 1);

        // R2: every bad selector with every opcode
        for (int s = N; s < 16; s++)
            for (int op = 0; op < 4; op++)
                cyc("R2 bad selector", 1, op, s, 0, 100 + s, 1);

        // R3 R7 R5: rates and directions per rail
        for (int r = 0; r < N; r++) begin
            int rates[4] = '{1, 7, 33, 250};
            for (int k = 0; k < 4; k++) begin
                cyc("R7 rate", 1, 1, r, 0, rates[k] * (k == 0 ? 5 : 1), 0);
                cyc("R3 up", 1, 0, r, 0, DV + 97 + 13 * k, 0);
                cyc("R11 no tick", 0, 0, 0, 0, 0, 0);
                settle("R5 ramp up");
                cyc("R3 down", 1, 0, r, 0, DV - 151 + k, 1);
                settle("R5 ramp down");
            end
        end

        // R3: extremes of the code range with rate 0 (R6)
        cyc("R6 rate zero", 1, 1, 2, 0, 0, 0);
        cyc("R3 full scale", 1, 0, 2, 0, 16'hFFFF, 0);
        cyc("R6 jump", 0, 0, 0, 0, 0, 1);
        cyc("R3 zero", 1, 0, 2, 0, 0, 0);
        cyc("R6 jump", 0, 0, 0, 0, 0, 1);

        // R3: retarget mid-ramp in the same cycle as a tick
        cyc("R7 rate", 1, 1, 0, 0, 20, 0);
        cyc("R3 up", 1, 0, 0, 0, DV + 200, 1);
        cyc("R5 tick", 0, 0, 0, 0, 0, 1);
        cyc("R3 reverse with tick", 1, 0, 0, 0, DV - 50, 1);
        settle("R5 reverse");

        // R4: staging, replacement, commit coinciding with a tick
        cyc("R4 stage r0", 1, 0, 0, 1, 900, 0);
        cyc("R4 stage r1", 1, 0, 1, 1, 950, 1);
        cyc("R4 restage r1", 1, 0, 1, 1, 700, 0);
        cyc("R4 stage r2", 1, 0, 2, 1, 500, 1);
        cyc("R4 commit via mode", 1, 3, 3, 0, 1, 1);
        settle("R4 after commit");

        // R4: committing command addressing a staged rail wins for that rail
        cyc("R4 stage r0", 1, 0, 0, 1, 1234, 0);
        cyc("R4 stage r3", 1, 0, 3, 1, 777, 0);
        cyc("R4 direct r0", 1, 0, 0, 0, 1000, 0);
        settle("R4 direct priority");

        // R2 with R4: bad selector does not commit
        cyc("R4 stage r1", 1, 0, 1, 1, 1111, 0);
        cyc("R2 no commit", 1, 1, 9, 0, 5, 1);
        cyc("R4 commit via rate", 1, 1, 2, 0, 40, 0);
        settle("R4 commit rate");

        // R8: default discards pending
        cyc("R8 stage r0", 1, 0, 0, 1, 3000, 0);
        cyc("R8 default r0", 1, 2, 0, 0, 0, 0);
        cyc("R8 commit other", 1, 3, 1, 0, 1, 0);
        settle("R8 back to default");
        for (int r = 0; r < N; r++) cyc("R8 default all", 1, 2, r, 0, 0, 1);
        settle("R8 settle");

        // R9: mode sweep
        for (int r = 0; r < N; r++) begin
            cyc("R9 mode set", 1, 3, r, 0, 3, 0);
            cyc("R9 mode clear", 1, 3, r, 0, 2, 0);
            cyc("R9 mode set again", 1, 3, r, 0, 1, 1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule